// File: doc/BRIEF.md
# Accumulator Processor Register Datapath

This block is the register file and shared data bus of a small 8-bit accumulator machine. It has six registers of mixed width: an accumulator, an instruction counter, a memory address register, a memory buffer, an opcode register and a second-operand register. They all run on one clock, and each has its own load strobe. One 8-bit bus carries data between them. Four of the registers can place their value on the bus. Each register that loads takes its value from the bus, except the instruction counter, which can instead take the output of its own wrapping incrementer.

The bus is not built from internal tri-state nets. It is a one-hot AND-OR selector. A separate enable output, `bus_oe`, marks whether the block is driving the bus. When no internal driver is enabled, the block floats: `bus_oe` is low and the loading registers take the external value on `bus_in`, which is where a memory outside the block would supply data. The opcode register feeds a one-hot decoder with one line for each opcode value.

An external sequencer supplies every control signal. The memory and the sequencer are not part of this block.

Top module: `acc_datapath`

## Requirements
- R1: An active-low `rst_n` asynchronously clears all six registers to zero. With every control low after reset, `bus_oe` is 0, `bus_out` is 0 and `op_dec` is 8'b0000_0001.
- R2: A register takes a new value on a rising clock edge only when its own load strobe is high. A register whose strobe is low keeps its value.
- R3: The accumulator, memory buffer and second-operand register load all 8 bus bits. The memory address register loads bus bits [4:0]. The opcode register loads bus bits [7:5].
- R4: With `ld_ic` and `ic_inc` both high, each edge adds one to the instruction counter modulo 32. The sequence runs 00, 01, ... 1F and then returns to 00.
- R5: With `ld_ic` high and `ic_inc` low, the instruction counter loads bus bits [4:0].
- R6: `op_dec` is one-hot. Bit k is set exactly when the opcode register holds k, in the same cycle as `op_q`.
- R7: Four enables put a register on the bus, in the same cycle, with no register in between: `oe_acc`, `oe_ic`, `oe_mb` and `oe_b`. While one of them is high, `bus_oe` is 1 and `bus_out` carries that register. The 5-bit counter is zero-extended, so bus bits [7:5] read 0.
- R8: At most one bus enable may be high at a time. When none is high, `bus_oe` is 0, `bus_out` is 0 and loads take `bus_in`.
- R9: While an internal driver is enabled, `bus_in` has no effect on any register that loads.
- R10: Several registers can load the same bus value on one edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low register clear |
| ld_acc | input | 1 | Load strobe, accumulator |
| ld_ic | input | 1 | Load strobe, instruction counter |
| ld_ma | input | 1 | Load strobe, memory address register |
| ld_mb | input | 1 | Load strobe, memory buffer |
| ld_op | input | 1 | Load strobe, opcode register |
| ld_b | input | 1 | Load strobe, second-operand register |
| ic_inc | input | 1 | Counter source: 1 = incrementer, 0 = bus |
| oe_acc | input | 1 | Accumulator drives the bus |
| oe_ic | input | 1 | Instruction counter drives the bus |
| oe_mb | input | 1 | Memory buffer drives the bus |
| oe_b | input | 1 | Second-operand register drives the bus |
| bus_in | input | 8 | External bus source, used when no internal driver is on |
| bus_out | output | 8 | Value the block drives onto the bus |
| bus_oe | output | 1 | High while the block drives the bus |
| acc_q | output | 8 | Accumulator |
| ic_q | output | 5 | Instruction counter |
| ma_q | output | 5 | Memory address register |
| mb_q | output | 8 | Memory buffer |
| op_q | output | 3 | Opcode register |
| b_q | output | 8 | Second-operand register |
| op_dec | output | 8 | One-hot decode of the opcode register |

## Verification
The bus outputs are combinational from the registers and the enables. The bench therefore samples `bus_out` and `bus_oe` a quarter period after it changes the controls, before the next rising edge. A register load takes one edge, so the register outputs and `op_dec` are checked just after that edge. The expected values are the result of the load that edge performed. The asynchronous clear is checked between edges, with no clock edge involved. The counter wrap is checked after each of 32 single-edge increments.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
   localparam int NUM_DRV = 4;
   typedef enum int {
      DRV_ACC = 0,
      DRV_IC  = 1,
      DRV_MB  = 2,
      DRV_B   = 3
   } drv_idx_e;
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("dp_reg: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (ld) q <= d;
   end

   // R2: the strobe alone decides whether the stored value moves
   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !ld |=> $stable(q));
   a_r2_take_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> q == $past(d));
endmodule

// File: rtl/dp_incr.sv
module dp_incr #(
   parameter int W      = 5,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   if (W < 1) begin : g_bad_w
      $error("dp_incr: W must be at least 1");
   end

   if (RIPPLE) begin : g_ripple
      logic [W-1:0] carry;
      assign carry[0] = 1'b1;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign y[i] = a[i] ^ carry[i];
         if (i < W - 1) begin : g_carry
            assign carry[i+1] = a[i] & carry[i];
         end
      end
   end else begin : g_adder
      assign y = W'(a + 1'b1);
   end
endmodule

// File: rtl/dp_onehot.sv
module dp_onehot #(
   parameter int IN_W = 3,
   localparam int OUT_W = 1 << IN_W
) (
   input  logic [IN_W-1:0]  a,
   output logic [OUT_W-1:0] y
);
   if (IN_W < 1 || IN_W > 8) begin : g_bad_w
      $error("dp_onehot: IN_W must be 1..8");
   end

   for (genvar k = 0; k < OUT_W; k++) begin : g_line
      localparam logic [IN_W-1:0] CODE = k;
      assign y[k] = (a == CODE);
   end
endmodule

// File: rtl/dp_bus.sv
module dp_bus #(
   parameter int W = 8,
   parameter int N = 4
) (
   input  logic [N-1:0][W-1:0] src,
   input  logic [N-1:0]        oe,
   input  logic [W-1:0]        ext,
   output logic [W-1:0]        drv_val,
   output logic                drv_en,
   output logic [W-1:0]        bus_val
);
   if (N < 1) begin : g_bad_n
      $error("dp_bus: N must be at least 1");
   end

   logic [N-1:0][W-1:0] masked;
   for (genvar i = 0; i < N; i++) begin : g_gate
      assign masked[i] = src[i] & {W{oe[i]}};
   end

   always_comb begin
      drv_val = '0;
      for (int i = 0; i < N; i++) drv_val = drv_val | masked[i];
   end

   assign drv_en  = |oe;
   assign bus_val = drv_en ? drv_val : ext;
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
   import acc_dp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int OP_W      = 3,
   parameter bit INC_RIPPLE = 1'b1,
   localparam int NOPS     = 1 << OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_acc,
   input  logic              ld_ic,
   input  logic              ld_ma,
   input  logic              ld_mb,
   input  logic              ld_op,
   input  logic              ld_b,
   input  logic              ic_inc,
   input  logic              oe_acc,
   input  logic              oe_ic,
   input  logic              oe_mb,
   input  logic              oe_b,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic [DATA_W-1:0] acc_q,
   output logic [ADDR_W-1:0] ic_q,
   output logic [ADDR_W-1:0] ma_q,
   output logic [DATA_W-1:0] mb_q,
   output logic [OP_W-1:0]   op_q,
   output logic [DATA_W-1:0] b_q,
   output logic [NOPS-1:0]   op_dec
);
   if (ADDR_W > DATA_W || OP_W > DATA_W) begin : g_bad_fields
      $error("acc_datapath: address and opcode fields must fit in DATA_W");
   end

   logic [NUM_DRV-1:0][DATA_W-1:0] drv_src;
   logic [NUM_DRV-1:0]             drv_oe;
   logic [DATA_W-1:0]              bus_val;
   logic [ADDR_W-1:0]              ic_next;
   logic [ADDR_W-1:0]              ic_d;

   // bus sources, indexed by the package enum
   always_comb begin
      drv_src          = '0;
      drv_src[DRV_ACC] = acc_q;
      drv_src[DRV_IC]  = DATA_W'(ic_q);
      drv_src[DRV_MB]  = mb_q;
      drv_src[DRV_B]   = b_q;
      drv_oe           = '0;
      drv_oe[DRV_ACC]  = oe_acc;
      drv_oe[DRV_IC]   = oe_ic;
      drv_oe[DRV_MB]   = oe_mb;
      drv_oe[DRV_B]    = oe_b;
   end

   dp_bus #(.W(DATA_W), .N(NUM_DRV)) u_bus (
      .src(drv_src), .oe(drv_oe), .ext(bus_in),
      .drv_val(bus_out), .drv_en(bus_oe), .bus_val(bus_val)
   );

   // R8: the sequencer never enables two drivers together
   a_r8_single_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_oe));
   // R7: the accumulator appears on the bus in the cycle it is enabled
   a_r7_acc_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
      oe_acc |-> (bus_oe && bus_out == acc_q));
   // R9: an internal driver wins over the external source
   a_r9_internal_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && ld_acc) |=> acc_q == $past(bus_out));

   dp_incr #(.W(ADDR_W), .RIPPLE(INC_RIPPLE)) u_incr (
      .a(ic_q), .y(ic_next)
   );

   assign ic_d = ic_inc ? ic_next : bus_val[ADDR_W-1:0];

   // R4 / R5: counter source selection
   a_r4_count_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ic && ic_inc) |=> ic_q == ADDR_W'($past(ic_q) + 1));
   a_r5_count_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_ic && !ic_inc) |=> ic_q == $past(bus_val[ADDR_W-1:0]));

   dp_reg #(.W(DATA_W)) u_acc (.clk(clk), .rst_n(rst_n), .ld(ld_acc),
      .d(bus_val), .q(acc_q));
   dp_reg #(.W(ADDR_W)) u_ic (.clk(clk), .rst_n(rst_n), .ld(ld_ic),
      .d(ic_d), .q(ic_q));
   dp_reg #(.W(ADDR_W)) u_ma (.clk(clk), .rst_n(rst_n), .ld(ld_ma),
      .d(bus_val[ADDR_W-1:0]), .q(ma_q));
   dp_reg #(.W(DATA_W)) u_mb (.clk(clk), .rst_n(rst_n), .ld(ld_mb),
      .d(bus_val), .q(mb_q));
   dp_reg #(.W(OP_W)) u_op (.clk(clk), .rst_n(rst_n), .ld(ld_op),
      .d(bus_val[DATA_W-1 -: OP_W]), .q(op_q));
   dp_reg #(.W(DATA_W)) u_b (.clk(clk), .rst_n(rst_n), .ld(ld_b),
      .d(bus_val), .q(b_q));

   dp_onehot #(.IN_W(OP_W)) u_dec (.a(op_q), .y(op_dec));

   // R6: exactly one decode line at all times
   a_r6_decode_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(op_dec));
endmodule

// File: tb/acc_datapath_test.sv
module acc_datapath_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_acc = 0, ld_ic = 0, ld_ma = 0, ld_mb = 0, ld_op = 0, ld_b = 0;
   logic       ic_inc = 0, oe_acc = 0, oe_ic = 0, oe_mb = 0, oe_b = 0;
   logic [7:0] bus_in = '0;
   logic [7:0] bus_out, acc_q, mb_q, b_q, op_dec;
   logic       bus_oe;
   logic [4:0] ic_q, ma_q;
   logic [2:0] op_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_datapath uut (
      .clk(clk), .rst_n(rst_n),
      .ld_acc(ld_acc), .ld_ic(ld_ic), .ld_ma(ld_ma), .ld_mb(ld_mb),
      .ld_op(ld_op), .ld_b(ld_b), .ic_inc(ic_inc),
      .oe_acc(oe_acc), .oe_ic(oe_ic), .oe_mb(oe_mb), .oe_b(oe_b),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
      .acc_q(acc_q), .ic_q(ic_q), .ma_q(ma_q), .mb_q(mb_q),
      .op_q(op_q), .b_q(b_q), .op_dec(op_dec)
   );

   // ld bits: acc ic ma mb op b ; oe bits: acc ic mb b
   typedef struct packed {
      logic [5:0] ld;
      logic       inc;
      logic [3:0] oe;
      logic [7:0] din;
      logic       boe;
      logic [7:0] bout;
      logic [7:0] a;
      logic [4:0] ic;
      logic [4:0] ma;
      logic [7:0] mb;
      logic [2:0] op;
      logic [7:0] b;
   } vec_t;

   localparam int NVEC = 13;
   localparam vec_t VECS [NVEC] = '{
      '{6'b100000,1'b0,4'b0000,8'hA5,1'b0,8'h00,8'hA5,5'h00,5'h00,8'h00,3'd0,8'h00}, // R2 R8
      '{6'b000100,1'b0,4'b0000,8'h3C,1'b0,8'h00,8'hA5,5'h00,5'h00,8'h3C,3'd0,8'h00}, // R2
      '{6'b001011,1'b0,4'b0000,8'hE7,1'b0,8'h00,8'hA5,5'h00,5'h07,8'h3C,3'd7,8'hE7}, // R3 R10
      '{6'b010000,1'b0,4'b0000,8'h5D,1'b0,8'h00,8'hA5,5'h1D,5'h07,8'h3C,3'd7,8'hE7}, // R5
      '{6'b010000,1'b1,4'b0000,8'h00,1'b0,8'h00,8'hA5,5'h1E,5'h07,8'h3C,3'd7,8'hE7}, // R4
      '{6'b010000,1'b1,4'b0000,8'h00,1'b0,8'h00,8'hA5,5'h1F,5'h07,8'h3C,3'd7,8'hE7}, // R4
      '{6'b010000,1'b1,4'b0000,8'h00,1'b0,8'h00,8'hA5,5'h00,5'h07,8'h3C,3'd7,8'hE7}, // R4 wrap
      '{6'b000001,1'b0,4'b1000,8'h11,1'b1,8'hA5,8'hA5,5'h00,5'h07,8'h3C,3'd7,8'hA5}, // R7 R9
      '{6'b100000,1'b0,4'b0010,8'hFF,1'b1,8'h3C,8'h3C,5'h00,5'h07,8'h3C,3'd7,8'hA5}, // R7 R9
      '{6'b010000,1'b1,4'b0000,8'h00,1'b0,8'h00,8'h3C,5'h01,5'h07,8'h3C,3'd7,8'hA5}, // R4
      '{6'b000100,1'b0,4'b0100,8'hFF,1'b1,8'h01,8'h3C,5'h01,5'h07,8'h01,3'd7,8'hA5}, // R7 zero-extend
      '{6'b001010,1'b0,4'b0001,8'h00,1'b1,8'hA5,8'h3C,5'h01,5'h05,8'h01,3'd5,8'hA5}, // R3 R7
      '{6'b000000,1'b0,4'b0000,8'h77,1'b0,8'h00,8'h3C,5'h01,5'h05,8'h01,3'd5,8'hA5}  // R2 hold
   };

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic drive(input logic [5:0] ld, input logic inc, input logic [3:0] oe,
                        input logic [7:0] din);
      {ld_acc, ld_ic, ld_ma, ld_mb, ld_op, ld_b} = ld;
      ic_inc = inc;
      {oe_acc, oe_ic, oe_mb, oe_b} = oe;
      bus_in = din;
   endtask

   task automatic check_regs(input string tag, input vec_t v);
      check({tag, " acc"}, 32'(acc_q), 32'(v.a));
      check({tag, " ic"},  32'(ic_q),  32'(v.ic));
      check({tag, " ma"},  32'(ma_q),  32'(v.ma));
      check({tag, " mb"},  32'(mb_q),  32'(v.mb));
      check({tag, " op"},  32'(op_q),  32'(v.op));
      check({tag, " b"},   32'(b_q),   32'(v.b));
      check("R6 decode", 32'(op_dec), 32'(8'b1 << v.op));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      vec_t zero_v;
      zero_v = '0;
      repeat (2) @(negedge clk);
      // R1: state straight after reset, controls idle
      check_regs("R1 reset", zero_v);
      check("R1 bus_oe", 32'(bus_oe), 0);
      check("R1 bus_out", 32'(bus_out), 0);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VECS[i].ld, VECS[i].inc, VECS[i].oe, VECS[i].din);
         #(CLK_PERIOD/4);
         check("R7/R8 bus_oe", 32'(bus_oe), 32'(VECS[i].boe));
         check("R7/R8 bus_out", 32'(bus_out), 32'(VECS[i].bout));
         @(posedge clk);
         #1;
         check_regs("R2/R3/R4/R5/R9/R10 table", VECS[i]);
      end

      // R4: full lap of the counter from a loaded 00
      @(negedge clk);
      drive(6'b010000, 1'b0, 4'b0000, 8'hE0);
      @(posedge clk); #1;
      check("R5 load zero", 32'(ic_q), 0);
      for (int n = 1; n <= 32; n++) begin
         @(negedge clk);
         drive(6'b010000, 1'b1, 4'b0000, 8'hFF);
         @(posedge clk); #1;
         check("R4 increment", 32'(ic_q), 32'(n % 32));
      end

      // R6: every opcode value, loaded from bus bits [7:5]
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         drive(6'b000010, 1'b0, 4'b0000, 8'(v << 5) | 8'h1F);
         @(posedge clk); #1;
         check("R3 op field", 32'(op_q), 32'(v));
         check("R6 one-hot", 32'(op_dec), 32'(8'b1 << v));
      end

      // R9: external source ignored while memory buffer drives; B takes mb
      @(negedge clk);
      drive(6'b000001, 1'b0, 4'b0010, 8'hC3);
      @(posedge clk); #1;
      check("R9 b ignores bus_in", 32'(b_q), 32'(8'h01));

      // R1: asynchronous clear between edges
      @(negedge clk);
      drive(6'b000000, 1'b0, 4'b0000, 8'h00);
      #1;
      rst_n = 1'b0;
      #1;
      zero_v = '0;
      check_regs("R1 async clear", zero_v);
      check("R1 bus float", 32'(bus_oe), 0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule